// File: doc/BRIEF.md
# Bus Wake-Up Pattern Detector

This block sits in the always-on domain of a bus transceiver. While the transceiver is parked in its low-power standby state it watches the single bit coming from the low-power bus comparator (`bus_dom`, 1 = dominant) and decides whether a remote node has sent a genuine wake request. The input is taken to be already synchronous to `clk`.

A wake request is a run of three bus phases in a fixed order: dominant, then recessive, then dominant. Each phase is qualified only when the bus holds that level for at least `FILT_CYC` consecutive clock samples. The whole request must finish inside a window of `TMO_CYC` cycles. The window opens when the first dominant phase qualifies. If the window closes before the final dominant phase qualifies, the partial progress is thrown away.

Once a request is accepted, `wake_flag` rises and stays up. The receive pin `rxd` stops idling high and starts to mirror the bus, low while the bus is dominant. Leaving standby or asserting reset returns everything to the idle state.

Top module: `bus_wake_detector`

## Requirements
- R1: With `stby_en` high, a qualified dominant phase, then a qualified recessive phase, then a qualified dominant phase set `wake_flag` to 1. It rises on the clock edge after the final dominant phase reaches `FILT_CYC` samples.
- R2: A phase qualifies after exactly `FILT_CYC` consecutive samples at one level. A phase of `FILT_CYC`-1 samples does not advance the sequence.
- R3: Any change of bus level restarts the run count for the new level. Short pieces of the same phase separated by a glitch are not added together.
- R4: The window opens when the first dominant phase qualifies. If the pattern is not complete `TMO_CYC` cycles later, the detector returns to idle, and a later dominant phase counts only as the first phase of a new pattern.
- R5: Once set, `wake_flag` stays 1 whatever the bus does, until `stby_en` goes low or reset is asserted.
- R6: While `wake_flag` is 0, `rxd` is 1, even while the bus is dominant.
- R7: While `wake_flag` is 1, `rxd` equals the inverse of `bus_dom` as sampled on the previous clock edge (dominant gives 0).
- R8: While `stby_en` is 0 the detector is held idle. `wake_flag` reads 0 on the cycle after `stby_en` falls, and progress made before that is discarded.
- R9: While `rst_n` is 0, `wake_flag` is 0 and `rxd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby_en | input | 1 | High while the transceiver is in standby |
| bus_dom | input | 1 | Comparator output, 1 = bus dominant |
| wake_flag | output | 1 | Valid wake request seen during this standby period |
| rxd | output | 1 | Receive data, low = dominant, held high before a wake |

## Verification
The bench goes after the filter boundary by sending each of the three phases one sample short. A detector that counted one cycle too generously would wake on these. It also splits phases with one- and two-sample glitches. A design that summed the run lengths instead of restarting them would wake on a pattern whose recessive phase was never continuous. A recessive phase held past the window, followed by a fresh dominant phase, catches a detector whose timeout is missing or fails to clear its progress. Dropping standby halfway through a pattern exposes a design that keeps stale state across standby periods. The receive pin is checked to stay high on a dominant bus before the wake and to track the bus afterwards, so a design that lets the bus through early or never opens the path is caught.

// File: rtl/bus_wake_pkg.sv
package bus_wake_pkg;

    typedef enum logic [1:0] {
        WK_IDLE    = 2'd0,
        WK_HAVE_D1 = 2'd1,
        WK_HAVE_R  = 2'd2,
        WK_AWAKE   = 2'd3
    } wk_state_e;

endpackage

// File: rtl/wake_run_filter.sv
module wake_run_filter #(
    parameter int FILT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bus_dom,
    output logic level,
    output logic qualified
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] SAT = CW'(FILT_CYC);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } run_t;

    run_t run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (clr) begin
            run_d.level = 1'b0;
            run_d.cnt   = '0;
        end else if (bus_dom != run_q.level) begin
            run_d.level = bus_dom;
            run_d.cnt   = CW'(1);
        end else if (run_q.cnt != SAT) begin
            run_d.cnt = run_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign level     = run_q.level;
    assign qualified = (run_q.cnt == SAT);

    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(run_q.level) && !$past(clr)) |-> (run_q.cnt == CW'(1))); // R3
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q.cnt <= SAT); // R2

endmodule

// File: rtl/wake_window_timer.sv
module wake_window_timer #(
    parameter int TMO_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != LAST) begin
            tmr_d.cnt = tmr_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = run && (tmr_q.cnt == LAST);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST); // R4
    AST_TMR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (tmr_q.cnt == '0)); // R4

endmodule

// File: rtl/bus_wake_detector.sv
module bus_wake_detector
    import bus_wake_pkg::*;
#(
    parameter int FILT_CYC = 16,
    parameter int TMO_CYC  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_en,
    input  logic bus_dom,
    output logic wake_flag,
    output logic rxd
);
    typedef struct packed {
        wk_state_e st;
    } seq_t;

    seq_t seq_d, seq_q;
    logic lvl, qual, tmo, win_run;

    wake_run_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!stby_en),
        .bus_dom   (bus_dom),
        .level     (lvl),
        .qualified (qual)
    );

    assign win_run = (seq_q.st == WK_HAVE_D1) || (seq_q.st == WK_HAVE_R);

    wake_window_timer #(.TMO_CYC(TMO_CYC)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (win_run),
        .expired (tmo)
    );

    always_comb begin
        seq_d = seq_q;
        if (!stby_en) begin
            seq_d.st = WK_IDLE;
        end else begin
            case (seq_q.st)
                WK_IDLE: begin
                    if (qual && lvl) seq_d.st = WK_HAVE_D1;
                end
                WK_HAVE_D1: begin
                    if (tmo)                seq_d.st = WK_IDLE;
                    else if (qual && !lvl)  seq_d.st = WK_HAVE_R;
                end
                WK_HAVE_R: begin
                    if (tmo)                seq_d.st = WK_IDLE;
                    else if (qual && lvl)   seq_d.st = WK_AWAKE;
                end
                WK_AWAKE: seq_d.st = WK_AWAKE;
                default:  seq_d.st = WK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st <= WK_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wake_flag = (seq_q.st == WK_AWAKE);
    assign rxd       = wake_flag ? !lvl : 1'b1;

    AST_WAKE_NEEDS_DOM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(qual && lvl)); // R1
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && stby_en) |=> wake_flag); // R5
    AST_STBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_en |=> !wake_flag); // R8
    AST_RXD_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_flag |-> rxd); // R6
    AST_TMO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && stby_en) |=> (seq_q.st == WK_IDLE)); // R4

endmodule

// File: tb/bus_wake_detector_test.sv
module bus_wake_detector_test;
    localparam int FILT = 4;
    localparam int TMO  = 40;
    localparam int NV   = 9;
    // phase lengths dom,rec,dom,rec,dom ; expected flag ; requirement number
    localparam int VEC [NV][7] = '{
        '{4, 4, 4, 0, 0, 1, 1},
        '{3, 4, 4, 0, 0, 0, 2},
        '{4, 3, 4, 0, 0, 0, 2},
        '{4, 4, 3, 0, 0, 0, 2},
        '{10, 10, 10, 0, 0, 1, 1},
        '{4, 60, 4, 0, 0, 0, 4},
        '{4, 2, 4, 4, 4, 1, 3},
        '{4, 2, 1, 2, 4, 0, 3},
        '{20, 4, 4, 0, 0, 1, 4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby_en = 1'b0;
    logic bus_dom = 1'b0;
    logic wake_flag, rxd;
    int   n_run = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    bus_wake_detector #(.FILT_CYC(FILT), .TMO_CYC(TMO)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .stby_en   (stby_en),
        .bus_dom   (bus_dom),
        .wake_flag (wake_flag),
        .rxd       (rxd)
    );

    function automatic string rtag(input int n);
        case (n)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic hold(input logic l, input int n);
        for (int i = 0; i < n; i++) begin
            bus_dom = l;
            @(negedge clk);
        end
    endtask

    task automatic restart_stby();
        stby_en = 1'b0;
        hold(1'b0, 2);
        stby_en = 1'b1;
        hold(1'b0, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(wake_flag, 1'b0, "R9 flag in reset");
        chk(rxd, 1'b1, "R9 rxd in reset");
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            stby_en = 1'b0;
            hold(1'b0, 2);
            chk(wake_flag, 1'b0, "R8 cleared outside standby");
            stby_en = 1'b1;
            hold(1'b0, 6);
            for (int p = 0; p < 5; p++) begin
                if (VEC[v][p] > 0) hold((p % 2) == 0, VEC[v][p]);
            end
            hold(1'b0, 3);
            chk(wake_flag, VEC[v][5] != 0, rtag(VEC[v][6]));
        end

        // R6: dominant bus before wake leaves rxd high
        restart_stby();
        hold(1'b1, 3);
        chk(rxd, 1'b1, "R6 rxd high on dominant before wake");
        hold(1'b1, 1);
        hold(1'b0, 4);
        hold(1'b1, 4);
        hold(1'b0, 1);
        chk(wake_flag, 1'b1, "R1 directed wake");
        // R7: rxd follows bus after wake
        hold(1'b1, 1);
        chk(rxd, 1'b0, "R7 rxd low on dominant");
        hold(1'b0, 1);
        chk(rxd, 1'b1, "R7 rxd high on recessive");
        hold(1'b1, 2);
        chk(rxd, 1'b0, "R7 rxd low again");
        // R5: flag survives long bus activity
        hold(1'b0, 50);
        chk(wake_flag, 1'b1, "R5 flag sticky");
        // R8: leaving standby clears
        stby_en = 1'b0;
        hold(1'b0, 1);
        chk(wake_flag, 1'b0, "R8 flag drops");
        chk(rxd, 1'b1, "R8 rxd high");
        // R8: progress discarded mid-pattern
        stby_en = 1'b1;
        hold(1'b0, 6);
        hold(1'b1, 4);
        hold(1'b0, 4);
        stby_en = 1'b0;
        hold(1'b0, 1);
        stby_en = 1'b1;
        hold(1'b1, 4);
        hold(1'b0, 3);
        chk(wake_flag, 1'b0, "R8 progress discarded");
        // R9: reset while awake
        hold(1'b1, 4);
        hold(1'b0, 4);
        hold(1'b1, 4);
        hold(1'b0, 1);
        chk(wake_flag, 1'b1, "R1 wake before reset");
        rst_n = 1'b0;
        hold(1'b1, 1);
        chk(wake_flag, 1'b0, "R9 flag after reset");
        chk(rxd, 1'b1, "R9 rxd after reset");
        rst_n = 1'b1;
        hold(1'b0, 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

endmodule